// File: doc/BRIEF.md
# Dual-Role Serial Control Port

This block links an internal processor to an external controller over a four-wire serial bus. A control bit selects its role. As a slave, the block takes bytes from the host into a receive queue and returns bytes from a transmit queue. The host supplies the clock and the chip-select. As a master, the block makes the serial clock from the system clock, drives its own peripheral select and its data output, and captures the returning line into the same receive queue.

The processor side is a small register port: a data address pushes to and pops from the queues, a control address holds the role bit and the fault status, and a divider address sets the bit rate. Two active-low outputs report queue state to the host: a message-ready interrupt and a receive-busy flag. If another master pulls the chip-select low while this block is master, the block drops off the bus and latches a fault bit. All external timing inputs are resampled into the system clock domain, so only one clock is used.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset, irqN=1, busyN=1, selOutN=1 and every output enable is 0. A read of address 1 returns 0x14, which means the transmit queue and the receive queue are both empty.
- R2: While the role bit (address 1, bit 0) is 0, sclkOe and mosiOe stay 0 and sclkOut stays 0. misoOe goes to 1 only while csN is low. While the role bit is 1, sclkOe and mosiOe are 1 and misoOe is 0.
- R3: In slave mode the block samples mosiIn on each rising edge of sclkIn while csN is low, MSB first. After the eighth bit it pushes the byte into the receive queue. A read of address 0 returns the oldest byte and removes it.
- R4: If csN is low while the role bit is 1, the block clears the role bit, releases its clock and data enables, and sets a sticky fault bit (address 1, bit 1). The fault bit stays set until software writes 1 to bit 1 of address 1.
- R5: irqN is 0 whenever the transmit queue holds a byte and 1 whenever the queue is empty. It goes low on the cycle after a write to address 0.
- R6: The receive queue holds 4 bytes. While it is full, busyN is 0 (address 1, bit 3 reads 1), and further received bytes are discarded. busyN returns to 1 after one read.
- R7: If csN rises before 8 bits of a byte have arrived, the partial byte is dropped and the next frame starts at bit 7.
- R8: In master mode, when the transmit queue is not empty, the block drives selOutN low. It then waits N system cycles before the first rising edge of sclkOut, and holds each clock phase for N cycles, where N is the value at address 2. It shifts out the byte MSB first, stores the 8 bits it sampled from misoIn in the receive queue, and then raises selOutN.
- R9: In slave mode the block presents the head of the transmit queue on misoOut, MSB first, from the fall of csN. It moves to the next bit on each falling edge of sclkIn. The byte leaves the queue when its first bit is clocked. If the queue is empty, the block sends 0x00.
- R10: The status read at address 1 has these fields: bit 0 role, bit 1 fault, bit 2 transmit empty, bit 3 receive full, bit 4 receive empty. Address 2 reads back the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 data, 1 control, 2 divider) |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Register read strobe (pops receive queue at address 0) |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data, combinational from rdAddr |
| sclkIn | input | 1 | Serial clock from an external master |
| sclkOut | output | 1 | Serial clock generated in master mode |
| sclkOe | output | 1 | Enable for sclkOut |
| csN | input | 1 | Active-low chip-select input |
| selOutN | output | 1 | Active-low peripheral select driven in master mode |
| mosiIn | input | 1 | Master-to-slave line, input side |
| mosiOut | output | 1 | Master-to-slave line, output side |
| mosiOe | output | 1 | Enable for mosiOut |
| misoIn | input | 1 | Slave-to-master line, input side |
| misoOut | output | 1 | Slave-to-master line, output side |
| misoOe | output | 1 | Enable for misoOut |
| irqN | output | 1 | Active-low message-ready flag |
| busyN | output | 1 | Active-low receive-full flag |

## Verification
Every slave-mode input passes two synchronizer flops and one edge register before it acts. A received bit or a shifted output bit therefore takes effect three system cycles after the pin changes. The bench holds each serial clock phase for six cycles and samples misoOut just before it raises sclkIn. Register writes act on the next edge: irqN, the status bits and the role outputs are checked on the following falling edge. A mode fault needs three cycles, so the bench waits five before it checks. In master mode, selOutN falls one cycle after the role write. The bench counts cycles on falling edges from that point, expecting the first clock rise after N cycles and each following rise 2N cycles later.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic clearBits;
  } dpStrobe_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
endpackage

// File: rtl/spi_ctl_fifo.sv
module spi_ctl_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end
endmodule

// File: rtl/spi_ctl_dp.sv
module spi_ctl_dp
  import spi_ctl_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int DEPTH      = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic                       serIn,
  input  logic                       hostWr,
  input  logic [FRAME_BITS-1:0]      hostWrData,
  input  logic                       hostRd,
  output logic                       serOut,
  output logic [$clog2(FRAME_BITS)-1:0] bitCnt,
  output logic [FRAME_BITS-1:0]      rxHead,
  output logic                       txEmpty,
  output logic                       txFull,
  output logic                       rxEmpty,
  output logic                       rxFull
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] txShift, txHead;
  logic [FRAME_BITS-2:0] rxShift;
  logic txLoaded, popTx, pushRx;

  assign popTx  = strobe.sampleRx && (bitCnt == '0) && txLoaded;
  assign pushRx = strobe.sampleRx && (bitCnt == CNT_W'(FRAME_BITS - 1));
  assign serOut = txShift[FRAME_BITS-1];

  spi_ctl_fifo #(.WIDTH(FRAME_BITS), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(hostWr), .din(hostWrData), .pop(popTx),
    .dout(txHead), .empty(txEmpty), .full(txFull)
  );

  spi_ctl_fifo #(.WIDTH(FRAME_BITS), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(pushRx), .din({rxShift, serIn}), .pop(hostRd),
    .dout(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      txLoaded <= 1'b0;
      rxShift  <= '0;
      bitCnt   <= '0;
    end else begin
      if (strobe.clearBits)     bitCnt <= '0;
      else if (strobe.sampleRx) bitCnt <= bitCnt + 1'b1;
      if (strobe.sampleRx) rxShift <= {rxShift[FRAME_BITS-3:0], serIn};
      if (strobe.loadTx) begin
        txShift  <= txEmpty ? '0 : txHead;
        txLoaded <= !txEmpty;
      end else begin
        if (strobe.shiftTx) txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
        if (popTx)          txLoaded <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_ctl_ctl.sv
module spi_ctl_ctl
  import spi_ctl_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int DIV_W      = 8,
  parameter int DIV_RESET  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sclkIn,
  input  logic                          csN,
  input  logic                          mosiIn,
  input  logic                          misoIn,
  input  logic                          wrEn,
  input  logic [1:0]                    wrAddr,
  input  logic [DIV_W-1:0]              wrData,
  input  logic [$clog2(FRAME_BITS)-1:0] bitCnt,
  input  logic                          txEmpty,
  output dpStrobe_t                     strobe,
  output logic                          serIn,
  output logic                          masterEn,
  output logic                          fault,
  output logic [DIV_W-1:0]              divN,
  output logic                          sclkOut,
  output logic                          selOut,
  output logic                          csLow
);
  typedef enum logic [1:0] {IDLE, LOWPH, HIGHPH} mState_t;

  logic [1:0] sclkS, csS, mosiS;
  logic sclkPrev, csPrev;
  logic sclkRise, sclkFall, csFall, csRise, faultNow, ctrlWr;
  logic phaseEnd, startXfer;
  logic [DIV_W-1:0] halfN, divCnt;
  mState_t state;

  assign csLow    = !csS[1];
  assign sclkRise = sclkS[1] && !sclkPrev;
  assign sclkFall = !sclkS[1] && sclkPrev;
  assign csFall   = csPrev && !csS[1];
  assign csRise   = !csPrev && csS[1];
  assign faultNow = masterEn && csLow;
  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign halfN    = (divN == '0) ? DIV_W'(1) : divN;
  assign phaseEnd = (divCnt == halfN - 1'b1);
  assign serIn    = masterEn ? misoIn : mosiS[1];
  assign startXfer = masterEn && !faultNow && (state == IDLE) && !txEmpty;

  always_comb begin
    strobe = '0;
    if (masterEn) begin
      if (!faultNow) begin
        strobe.loadTx    = startXfer;
        strobe.clearBits = startXfer;
        strobe.sampleRx  = (state == LOWPH) && phaseEnd;
        strobe.shiftTx   = (state == HIGHPH) && phaseEnd && (bitCnt != '0);
      end
    end else begin
      strobe.clearBits = csFall || csRise;
      strobe.sampleRx  = sclkRise && csLow;
      strobe.shiftTx   = sclkFall && csLow && (bitCnt != '0);
      strobe.loadTx    = csFall || (sclkFall && csLow && (bitCnt == '0));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkS <= '0; csS <= 2'b11; mosiS <= '0;
      sclkPrev <= 1'b0; csPrev <= 1'b1;
    end else begin
      sclkS <= {sclkS[0], sclkIn};
      csS   <= {csS[0], csN};
      mosiS <= {mosiS[0], mosiIn};
      sclkPrev <= sclkS[1];
      csPrev   <= csS[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterEn <= 1'b0; fault <= 1'b0; divN <= DIV_W'(DIV_RESET);
      state <= IDLE; divCnt <= '0; sclkOut <= 1'b0; selOut <= 1'b0;
    end else if (faultNow) begin
      fault <= 1'b1; masterEn <= 1'b0;
      state <= IDLE; divCnt <= '0; sclkOut <= 1'b0; selOut <= 1'b0;
    end else begin
      if (ctrlWr) begin
        masterEn <= wrData[0];
        if (wrData[1]) fault <= 1'b0;
      end
      if (wrEn && (wrAddr == ADDR_DIV)) divN <= wrData;
      if (!masterEn) begin
        state <= IDLE; divCnt <= '0; sclkOut <= 1'b0; selOut <= 1'b0;
      end else begin
        case (state)
          IDLE: if (startXfer) begin
            selOut <= 1'b1; divCnt <= '0; state <= LOWPH;
          end
          LOWPH: if (phaseEnd) begin
            divCnt <= '0; sclkOut <= 1'b1; state <= HIGHPH;
          end else divCnt <= divCnt + 1'b1;
          HIGHPH: if (phaseEnd) begin
            divCnt <= '0; sclkOut <= 1'b0;
            if (bitCnt == '0) begin
              selOut <= 1'b0; state <= IDLE;
            end else state <= LOWPH;
          end else divCnt <= divCnt + 1'b1;
          default: state <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int DEPTH      = 4,
  parameter int DIV_RESET  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [FRAME_BITS-1:0] wrData,
  input  logic                  rdEn,
  input  logic [1:0]            rdAddr,
  output logic [FRAME_BITS-1:0] rdData,
  input  logic                  sclkIn,
  output logic                  sclkOut,
  output logic                  sclkOe,
  input  logic                  csN,
  output logic                  selOutN,
  input  logic                  mosiIn,
  output logic                  mosiOut,
  output logic                  mosiOe,
  input  logic                  misoIn,
  output logic                  misoOut,
  output logic                  misoOe,
  output logic                  irqN,
  output logic                  busyN
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  dpStrobe_t strobe;
  logic serIn, serOut, masterEn, fault, selOut, csLow;
  logic txEmpty, txFull, rxEmpty, rxFull;
  logic [CNT_W-1:0] bitCnt;
  logic [FRAME_BITS-1:0] rxHead, divN;

  spi_ctl_ctl #(.FRAME_BITS(FRAME_BITS), .DIV_W(FRAME_BITS), .DIV_RESET(DIV_RESET)) u_ctl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csN(csN), .mosiIn(mosiIn), .misoIn(misoIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .bitCnt(bitCnt), .txEmpty(txEmpty),
    .strobe(strobe), .serIn(serIn), .masterEn(masterEn), .fault(fault), .divN(divN),
    .sclkOut(sclkOut), .selOut(selOut), .csLow(csLow)
  );

  spi_ctl_dp #(.FRAME_BITS(FRAME_BITS), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serIn(serIn),
    .hostWr(wrEn && (wrAddr == ADDR_DATA)), .hostWrData(wrData),
    .hostRd(rdEn && (rdAddr == ADDR_DATA)),
    .serOut(serOut), .bitCnt(bitCnt), .rxHead(rxHead),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull)
  );

  assign sclkOe  = masterEn;
  assign mosiOe  = masterEn;
  assign mosiOut = serOut;
  assign misoOut = serOut;
  assign misoOe  = !masterEn && csLow;
  assign selOutN = !selOut;
  assign irqN    = txEmpty;
  assign busyN   = !rxFull;

  always_comb begin
    case (rdAddr)
      ADDR_DATA: rdData = rxHead;
      ADDR_CTRL: rdData = {{(FRAME_BITS-5){1'b0}}, rxEmpty, rxFull, txEmpty, fault, masterEn};
      ADDR_DIV:  rdData = divN;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_ctl_checker.sv
module spi_ctl_checker (
  input logic clk,
  input logic rstN,
  input logic dataWr,
  input logic ctlClr,
  input logic dataRd,
  input logic sclkOut,
  input logic sclkOe,
  input logic mosiOe,
  input logic misoOe,
  input logic selOutN,
  input logic irqN,
  input logic busyN,
  input logic masterEn,
  input logic fault,
  input logic txFull
);
  p_slave_clk_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sclkOe |-> !sclkOut);

  p_miso_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    masterEn |-> !misoOe);

  p_fault_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fault) |-> (!masterEn && !sclkOe && !mosiOe));

  p_fault_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !ctlClr) |=> fault);

  p_irq_on_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !txFull) |=> !irqN);

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && !dataRd) |=> !busyN);

  p_clk_in_select_r8: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |-> !selOutN);
endmodule

bind spi_ctl_port spi_ctl_checker u_chk (
  .clk(clk), .rstN(rstN),
  .dataWr(wrEn && (wrAddr == 2'd0)),
  .ctlClr(wrEn && (wrAddr == 2'd1) && wrData[1]),
  .dataRd(rdEn && (rdAddr == 2'd0)),
  .sclkOut(sclkOut), .sclkOe(sclkOe), .mosiOe(mosiOe), .misoOe(misoOe),
  .selOutN(selOutN), .irqN(irqN), .busyN(busyN),
  .masterEn(masterEn), .fault(fault), .txFull(txFull)
);

// File: tb/spi_ctl_port_bench.sv
module spi_ctl_port_bench;
  localparam int H = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, rdEn = 0;
  logic [1:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0, rdData;
  logic sclkIn = 0, csN = 1, mosiIn = 0, misoIn;
  logic sclkOut, sclkOe, selOutN, mosiOut, mosiOe, misoOut, misoOe, irqN, busyN;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] hostTx [8];
  logic [7:0] hostRx [8];

  always #4 clk = ~clk;
  assign misoIn = ~mosiOut;

  spi_ctl_port u_spi_ctl_port (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .sclkOe(sclkOe), .csN(csN), .selOutN(selOutN),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .irqN(irqN), .busyN(busyN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // host-side frame: nBytes full bytes, or only partBits bits of byte 0 when partBits > 0
  task automatic hostFrame(input int nBytes, input int partBits);
    csN = 1'b0;
    idle(8);
    for (int b = 0; b < nBytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (partBits > 0 && (7 - i) >= partBits) break;
        mosiIn = hostTx[b][i];
        idle(H);
        hostRx[b][i] = misoOut;
        sclkIn = 1'b1;
        idle(H);
        sclkIn = 1'b0;
      end
    end
    idle(H);
    csN = 1'b1;
    idle(8);
  endtask

  task automatic testReset;
    logic [7:0] d;
    check("R1 irqN", irqN, 1);
    check("R1 busyN", busyN, 1);
    check("R1 selOutN", selOutN, 1);
    check("R1 enables", {sclkOe, mosiOe, misoOe}, 0);
    readReg(2'd1, d);
    check("R1 R10 status", d, 8'h14);
  endtask

  task automatic testSlaveXfer;
    logic [7:0] d;
    writeReg(2'd0, 8'h3C);
    check("R5 irqN low after write", irqN, 0);
    hostTx[0] = 8'h5A; hostTx[1] = 8'h11;
    csN = 1'b0; idle(5);
    check("R2 misoOe when selected", misoOe, 1);
    check("R2 no clock drive in slave", {sclkOe, mosiOe, sclkOut}, 0);
    csN = 1'b1; idle(8);
    hostFrame(2, 0);
    check("R9 first byte out", hostRx[0], 8'h3C);
    check("R9 empty queue sends zero", hostRx[1], 8'h00);
    check("R5 irqN high when drained", irqN, 1);
    readReg(2'd0, d); check("R3 first byte in", d, 8'h5A);
    readReg(2'd0, d); check("R3 second byte in", d, 8'h11);
    readReg(2'd1, d); check("R10 rx empty bit", d[4], 1);
  endtask

  task automatic testPartial;
    logic [7:0] d;
    hostTx[0] = 8'hFF;
    hostFrame(1, 5);
    readReg(2'd1, d); check("R7 partial not stored", d[4], 1);
    hostTx[0] = 8'h81;
    hostFrame(1, 0);
    readReg(2'd0, d); check("R7 next frame aligned", d, 8'h81);
    readReg(2'd1, d); check("R7 only one byte", d[4], 1);
  endtask

  task automatic testFull;
    logic [7:0] d;
    for (int i = 0; i < 5; i++) hostTx[i] = 8'h10 + 8'(i);
    hostFrame(5, 0);
    check("R6 busyN low when full", busyN, 0);
    readReg(2'd1, d); check("R6 status full bit", d[3], 1);
    for (int i = 0; i < 4; i++) begin
      readReg(2'd0, d);
      check("R6 order kept, fifth dropped", d, 8'h10 + 8'(i));
      if (i == 0) check("R6 busyN released", busyN, 1);
    end
    readReg(2'd1, d); check("R6 queue empty after four", d[4], 1);
  endtask

  task automatic testMaster;
    logic [7:0] d, cap;
    int cyc, selFall, firstRise, lastRise, nRise, gapBad;
    logic prevSclk, prevSel;
    writeReg(2'd2, 8'd2);
    readReg(2'd2, d); check("R10 divider readback", d, 8'd2);
    writeReg(2'd0, 8'hC3);
    writeReg(2'd1, 8'h01);
    check("R2 master enables", {sclkOe, mosiOe, misoOe}, 3'b110);
    cyc = 0; selFall = -1; firstRise = -1; lastRise = -1; nRise = 0; gapBad = 0; cap = 0;
    prevSclk = sclkOut; prevSel = 1'b1;
    while (cyc < 200) begin
      if (!selOutN && prevSel) selFall = cyc;
      if (sclkOut && !prevSclk) begin
        if (nRise == 0) firstRise = cyc;
        else if (cyc - lastRise != 4) gapBad++;
        lastRise = cyc;
        cap[7 - nRise] = mosiOut;
        nRise++;
      end
      if (selOutN && !prevSel) break;
      prevSclk = sclkOut; prevSel = selOutN;
      @(negedge clk); cyc++;
    end
    check("R8 setup half bit", firstRise - selFall, 2);
    check("R8 clock period 2N", gapBad, 0);
    check("R8 eight clocks", nRise, 8);
    check("R8 MSB-first data out", cap, 8'hC3);
    idle(2);
    readReg(2'd0, d); check("R8 sampled byte stored", d, 8'h3C);
    check("R5 irqN high after send", irqN, 1);
  endtask

  task automatic testFault;
    logic [7:0] d;
    csN = 1'b0; idle(5);
    check("R4 outputs released", {sclkOe, mosiOe}, 0);
    readReg(2'd1, d); check("R4 fault set, role cleared", d[1:0], 2'b10);
    csN = 1'b1; idle(4);
    readReg(2'd1, d); check("R4 fault sticky", d[1], 1);
    writeReg(2'd1, 8'h02);
    readReg(2'd1, d); check("R4 fault cleared by write", d[1], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset;
    testSlaveXfer;
    testPartial;
    testFull;
    testMaster;
    testFault;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule